// File: doc/BRIEF.md
# External Data Move Router for On-Chip XRAM

This block sits between a small 8-bit controller core and its memory pins. For every external-data move the core issues, it decides whether the on-chip XRAM or external memory serves the access. It then runs the access as a fixed sequence of phases, driving the port-mode controls of the low and high address/data ports, the active-low read and write strobes, and the XRAM enable.

A request carries four things: the addressing form, the read/write direction, the write data and the address. The form is either a 16-bit data pointer, or an 8-bit register combined with a page register. The block compares the relevant high address byte against a configurable XRAM page value. A two-bit mapping field and the level of the external-access pin then pick the target. In one mapping the on-chip XRAM serves the access while the external strobes still pulse and write data still appears on the bus, so external logic can observe the traffic.

The page value and the mapping field are loaded through a simple write port. The decision uses the values held at the moment a request is accepted.

Top module: `xram_access_router`

## Requirements
- R1: After reset the mapping field is 00, the page value is 0xF8, no access is in progress (busy_o low), both strobes are high and neither port is in bus mode.
- R2: The compared byte is req_addr_i[15:8] when req_ptr_i is 1 (pointer form) and req_page_i when req_ptr_i is 0 (register form). The access hits when that byte equals the page value.
- R3: On a miss, external memory serves the access. The low port enters bus mode and the strobe for the access direction is pulsed, whatever the mapping and pin level.
- R4: For register-form accesses, hi_bus_o is never asserted.
- R5: Hit, mapping 00, ext_acc_i low: XRAM serves the access and no strobe pulses. The low port, and for pointer form the high port, enter bus mode only on writes.
- R6: Hit, mapping 10 (either pin level): XRAM serves the access, the direction strobe still pulses, and on writes the ports enter bus mode as in R5.
- R7: When mapping bit 0 is 1 (01 or 11), external memory serves every access, including hits, behaving as in R3.
- R8: Hit, mapping 00, ext_acc_i high: XRAM serves the access. Neither port enters bus mode and no strobe pulses.
- R9: A read served by XRAM never puts either port in bus mode.
- R10: A request accepted at a rising edge while idle produces three states: the address phase for the next cycle, the strobe phase for the cycle after, and one cycle with done_o high. Strobes are low only in the strobe phase, and never both at once.
- R11: On a read, rdata_o holds, from the done cycle on, the value of xram_rdata_i (XRAM target) or lo_in_i (external target) sampled at the end of the strobe phase.
- R12: xram_en_o is high only in the strobe phase of an XRAM-served access, and xram_we_o only when that access is a write. xram_addr_o is the pointer, or {req_page_i, req_addr_i[7:0]} for register form.
- R13: A request presented while an access is in progress is ignored. It is neither queued nor started later.
- R14: In bus mode, the address phase drives the low address byte on lo_out_o and the high byte on hi_out_o. The strobe phase drives the write data on lo_out_o for writes (0 for reads) and keeps the high byte on hi_out_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Load page value and mapping field |
| cfg_page_i | input | 8 | New XRAM page value |
| cfg_map_i | input | 2 | New mapping field |
| ext_acc_i | input | 1 | External-access pin level |
| req_valid_i | input | 1 | Move request present |
| req_ptr_i | input | 1 | 1 = pointer form, 0 = register form |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 16 | Pointer, or register value in bits 7:0 |
| req_page_i | input | 8 | Page register for register form |
| req_wdata_i | input | 8 | Write data |
| busy_o | output | 1 | Access in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 8 | Read data returned to the core |
| lo_bus_o | output | 1 | Low port in bus mode |
| lo_out_o | output | 8 | Low port bus value |
| lo_in_i | input | 8 | Low port pin data |
| hi_bus_o | output | 1 | High port in bus mode |
| hi_out_o | output | 8 | High port bus value |
| rd_n_o | output | 1 | External read strobe, active low |
| wr_n_o | output | 1 | External write strobe, active low |
| xram_en_o | output | 1 | XRAM access enable |
| xram_we_o | output | 1 | XRAM write enable |
| xram_addr_o | output | 16 | XRAM address |
| xram_wdata_o | output | 8 | XRAM write data |
| xram_rdata_i | input | 8 | XRAM read data |

## Verification
A request driven before a rising edge produces the following, counting from that edge: the address phase is visible in the first cycle, the strobe phase and XRAM enable in the second, and done_o with the captured read data in the third. Inputs change on falling edges. The reference model advances on rising edges and is compared against every output on each falling edge, so each result is checked in exactly the cycle it is due. Per-access monitors sample strobes, bus modes and the XRAM address at rising edges. Each access then checks both its three-cycle latency and the routing that its mapping, pin level and compared byte call for.

// File: rtl/xram_rt_pkg.sv
`timescale 1ns/1ps
package xram_rt_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_STRB = 2'd2,
    PH_DONE = 2'd3
  } phase_e;

  typedef struct packed {
    logic use_xram;
    logic strobe;
    logic lo_bus;
    logic hi_bus;
  } route_t;

  localparam int unsigned MapExtBit  = 0;  // forces external target
  localparam int unsigned MapStrbBit = 1;  // XRAM target with visible strobes
endpackage

// File: rtl/xram_rt_cfg.sv
`timescale 1ns/1ps
module xram_rt_cfg #(
  parameter int unsigned PAGE_W   = 8,
  parameter logic [PAGE_W-1:0] PAGE_RST = 8'hF8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic [1:0]        map_i,
  output logic [PAGE_W-1:0] page_o,
  output logic [1:0]        map_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      page_o <= PAGE_RST;
      map_o  <= 2'b00;
    end else if (we_i) begin
      page_o <= page_i;
      map_o  <= map_i;
    end
  end
endmodule

// File: rtl/xram_rt_decode.sv
`timescale 1ns/1ps
module xram_rt_decode
  import xram_rt_pkg::*;
#(
  parameter int unsigned PAGE_W = 8
) (
  input  logic              ptr_form_i,
  input  logic              write_i,
  input  logic [PAGE_W-1:0] addr_hi_i,
  input  logic [PAGE_W-1:0] page_reg_i,
  input  logic [PAGE_W-1:0] cfg_page_i,
  input  logic [1:0]        map_i,
  input  logic              ext_acc_i,
  output route_t            route_o
);
  logic [PAGE_W-1:0] cmp_byte;
  logic              hit;

  assign cmp_byte = ptr_form_i ? addr_hi_i : page_reg_i;
  assign hit      = (cmp_byte == cfg_page_i);

  always_comb begin
    // external target by default
    route_o.use_xram = 1'b0;
    route_o.strobe   = 1'b1;
    route_o.lo_bus   = 1'b1;
    route_o.hi_bus   = ptr_form_i;
    if (hit && !map_i[MapExtBit]) begin
      route_o.use_xram = 1'b1;
      if (map_i[MapStrbBit]) begin
        route_o.strobe = 1'b1;
        route_o.lo_bus = write_i;
        route_o.hi_bus = write_i & ptr_form_i;
      end else if (ext_acc_i) begin
        route_o.strobe = 1'b0;
        route_o.lo_bus = 1'b0;
        route_o.hi_bus = 1'b0;
      end else begin
        route_o.strobe = 1'b0;
        route_o.lo_bus = write_i;
        route_o.hi_bus = write_i & ptr_form_i;
      end
    end
  end
endmodule

// File: rtl/xram_rt_seq.sv
`timescale 1ns/1ps
module xram_rt_seq
  import xram_rt_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned ADDR_W = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              ptr_form_i,
  input  logic              write_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] page_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  route_t            route_i,
  input  logic [DATA_W-1:0] lo_in_i,
  input  logic [DATA_W-1:0] xram_rdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              lo_bus_o,
  output logic [DATA_W-1:0] lo_out_o,
  output logic              hi_bus_o,
  output logic [DATA_W-1:0] hi_out_o,
  output logic              rd_n_o,
  output logic              wr_n_o,
  output logic              xram_en_o,
  output logic              xram_we_o,
  output logic [ADDR_W-1:0] xram_addr_o,
  output logic [DATA_W-1:0] xram_wdata_o,
  output logic              cur_ptr_o
);
  phase_e            ph_q, ph_d;
  route_t            rt_q;
  logic              wr_q, ptr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic              accept, bus_ph, strb_ph;

  assign accept = (ph_q == PH_IDLE) && req_valid_i;

  always_comb begin
    ph_d = ph_q;
    unique case (ph_q)
      PH_IDLE: if (accept) ph_d = PH_ADDR;
      PH_ADDR: ph_d = PH_STRB;
      PH_STRB: ph_d = PH_DONE;
      PH_DONE: ph_d = PH_IDLE;
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q    <= PH_IDLE;
      rt_q    <= '0;
      wr_q    <= 1'b0;
      ptr_q   <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      ph_q <= ph_d;
      if (accept) begin
        rt_q    <= route_i;
        wr_q    <= write_i;
        ptr_q   <= ptr_form_i;
        addr_q  <= ptr_form_i ? addr_i : {page_i, addr_i[DATA_W-1:0]};
        wdata_q <= wdata_i;
      end
      if (ph_q == PH_STRB && !wr_q)
        rdata_q <= rt_q.use_xram ? xram_rdata_i : lo_in_i;
    end
  end

  assign bus_ph  = (ph_q == PH_ADDR) || (ph_q == PH_STRB);
  assign strb_ph = (ph_q == PH_STRB);

  assign busy_o    = (ph_q != PH_IDLE);
  assign done_o    = (ph_q == PH_DONE);
  assign rdata_o   = rdata_q;
  assign cur_ptr_o = ptr_q;

  assign lo_bus_o = bus_ph & rt_q.lo_bus;
  assign hi_bus_o = bus_ph & rt_q.hi_bus;

  always_comb begin
    lo_out_o = '0;
    if (lo_bus_o) begin
      if (ph_q == PH_ADDR) lo_out_o = addr_q[DATA_W-1:0];
      else if (wr_q)       lo_out_o = wdata_q;
    end
  end
  assign hi_out_o = hi_bus_o ? addr_q[ADDR_W-1:DATA_W] : '0;

  assign rd_n_o = ~(strb_ph & rt_q.strobe & ~wr_q);
  assign wr_n_o = ~(strb_ph & rt_q.strobe & wr_q);

  assign xram_en_o    = strb_ph & rt_q.use_xram;
  assign xram_we_o    = xram_en_o & wr_q;
  assign xram_addr_o  = addr_q;
  assign xram_wdata_o = wdata_q;
endmodule

// File: rtl/xram_access_router.sv
`timescale 1ns/1ps
module xram_access_router
  import xram_rt_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter logic [DATA_W-1:0] PAGE_RST = 8'hF8,
  localparam int unsigned ADDR_W = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [DATA_W-1:0] cfg_page_i,
  input  logic [1:0]        cfg_map_i,
  input  logic              ext_acc_i,
  input  logic              req_valid_i,
  input  logic              req_ptr_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_page_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              lo_bus_o,
  output logic [DATA_W-1:0] lo_out_o,
  input  logic [DATA_W-1:0] lo_in_i,
  output logic              hi_bus_o,
  output logic [DATA_W-1:0] hi_out_o,
  output logic              rd_n_o,
  output logic              wr_n_o,
  output logic              xram_en_o,
  output logic              xram_we_o,
  output logic [ADDR_W-1:0] xram_addr_o,
  output logic [DATA_W-1:0] xram_wdata_o,
  input  logic [DATA_W-1:0] xram_rdata_i
);
  logic [DATA_W-1:0] cfg_page;
  logic [1:0]        cfg_map;
  route_t            route;
  logic              cur_ptr;

  xram_rt_cfg #(.PAGE_W(DATA_W), .PAGE_RST(PAGE_RST)) u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (cfg_we_i),
    .page_i (cfg_page_i),
    .map_i  (cfg_map_i),
    .page_o (cfg_page),
    .map_o  (cfg_map)
  );

  xram_rt_decode #(.PAGE_W(DATA_W)) u_dec (
    .ptr_form_i (req_ptr_i),
    .write_i    (req_write_i),
    .addr_hi_i  (req_addr_i[ADDR_W-1:DATA_W]),
    .page_reg_i (req_page_i),
    .cfg_page_i (cfg_page),
    .map_i      (cfg_map),
    .ext_acc_i  (ext_acc_i),
    .route_o    (route)
  );

  xram_rt_seq #(.DATA_W(DATA_W)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_valid_i  (req_valid_i),
    .ptr_form_i   (req_ptr_i),
    .write_i      (req_write_i),
    .addr_i       (req_addr_i),
    .page_i       (req_page_i),
    .wdata_i      (req_wdata_i),
    .route_i      (route),
    .lo_in_i      (lo_in_i),
    .xram_rdata_i (xram_rdata_i),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .rdata_o      (rdata_o),
    .lo_bus_o     (lo_bus_o),
    .lo_out_o     (lo_out_o),
    .hi_bus_o     (hi_bus_o),
    .hi_out_o     (hi_out_o),
    .rd_n_o       (rd_n_o),
    .wr_n_o       (wr_n_o),
    .xram_en_o    (xram_en_o),
    .xram_we_o    (xram_we_o),
    .xram_addr_o  (xram_addr_o),
    .xram_wdata_o (xram_wdata_o),
    .cur_ptr_o    (cur_ptr)
  );
endmodule

// File: rtl/xram_access_router_chk.sv
`timescale 1ns/1ps
module xram_access_router_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic req_valid_i,
  input logic busy_o,
  input logic done_o,
  input logic lo_bus_o,
  input logic hi_bus_o,
  input logic rd_n_o,
  input logic wr_n_o,
  input logic xram_en_o,
  input logic xram_we_o,
  input logic cur_ptr
);
  p_strobe_excl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_n_o || wr_n_o));

  p_strobe_single_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_n_o || !wr_n_o) |=> (rd_n_o && wr_n_o && done_o));

  p_done_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_accept_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && req_valid_i) |=> (busy_o && !done_o));

  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (rd_n_o && wr_n_o && !lo_bus_o && !hi_bus_o && !xram_en_o));

  p_hi_io_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_bus_o |-> cur_ptr);

  p_xram_rd_nobus_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xram_en_o && !xram_we_o) |-> (!lo_bus_o && !hi_bus_o));

  p_xram_we_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xram_we_o |-> xram_en_o);

  p_xram_en_single_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xram_en_o |=> (!xram_en_o && done_o));
endmodule

bind xram_access_router xram_access_router_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .lo_bus_o    (lo_bus_o),
  .hi_bus_o    (hi_bus_o),
  .rd_n_o      (rd_n_o),
  .wr_n_o      (wr_n_o),
  .xram_en_o   (xram_en_o),
  .xram_we_o   (xram_we_o),
  .cur_ptr     (cur_ptr)
);

// File: tb/xram_access_router_bench.sv
`timescale 1ns/1ps
module xram_access_router_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [7:0]  cfg_page_i = '0;
  logic [1:0]  cfg_map_i = '0;
  logic        ext_acc_i = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ptr_i = 1'b0;
  logic        req_write_i = 1'b0;
  logic [15:0] req_addr_i = '0;
  logic [7:0]  req_page_i = '0;
  logic [7:0]  req_wdata_i = '0;
  logic [7:0]  lo_in_i = '0;
  logic [7:0]  xram_rdata_i = '0;
  logic        busy_o, done_o, lo_bus_o, hi_bus_o, rd_n_o, wr_n_o, xram_en_o, xram_we_o;
  logic [7:0]  rdata_o, lo_out_o, hi_out_o, xram_wdata_o;
  logic [15:0] xram_addr_o;

  always #2 clk_i = ~clk_i;  // 250 MHz

  xram_access_router u_xram_access_router (.*);

  int total = 0;
  int bad = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  int          m_ph;
  bit          m_x, m_stb, m_lo, m_hi, m_wr;
  logic [15:0] m_addr;
  logic [7:0]  m_wd, m_rd, m_page;
  logic [1:0]  m_map;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_ph <= 0; m_page <= 8'hF8; m_map <= 2'b00; m_rd <= 8'h00;
      m_x <= 0; m_stb <= 0; m_lo <= 0; m_hi <= 0; m_wr <= 0; m_addr <= 0; m_wd <= 0;
    end else begin
      if (cfg_we_i) begin m_page <= cfg_page_i; m_map <= cfg_map_i; end
      if (m_ph == 0) begin
        if (req_valid_i) begin
          logic [7:0] cb;
          m_ph <= 1;
          m_wr <= req_write_i;
          m_wd <= req_wdata_i;
          m_addr <= req_ptr_i ? req_addr_i : {req_page_i, req_addr_i[7:0]};
          cb = req_ptr_i ? req_addr_i[15:8] : req_page_i;
          if (cb != m_page || m_map == 2'b01 || m_map == 2'b11) begin
            m_x <= 0; m_stb <= 1; m_lo <= 1; m_hi <= req_ptr_i;
          end else if (m_map == 2'b10) begin
            m_x <= 1; m_stb <= 1; m_lo <= req_write_i; m_hi <= req_write_i && req_ptr_i;
          end else if (ext_acc_i) begin
            m_x <= 1; m_stb <= 0; m_lo <= 0; m_hi <= 0;
          end else begin
            m_x <= 1; m_stb <= 0; m_lo <= req_write_i; m_hi <= req_write_i && req_ptr_i;
          end
        end
      end else if (m_ph == 1) m_ph <= 2;
      else if (m_ph == 2) begin
        m_ph <= 3;
        if (!m_wr) m_rd <= m_x ? xram_rdata_i : lo_in_i;
      end else m_ph <= 0;
    end
  end

  always @(negedge clk_i) begin
    if (rst_ni && !finished) begin
      bit e_lo, e_hi;
      e_lo = (m_ph == 1 || m_ph == 2) && m_lo;
      e_hi = (m_ph == 1 || m_ph == 2) && m_hi;
      check(busy_o == (m_ph != 0), "R13 busy", busy_o, m_ph != 0);
      check(done_o == (m_ph == 3), "R10 done", done_o, m_ph == 3);
      check(rd_n_o == !(m_ph == 2 && m_stb && !m_wr), "R10 rd_n", rd_n_o, !(m_ph == 2 && m_stb && !m_wr));
      check(wr_n_o == !(m_ph == 2 && m_stb && m_wr), "R10 wr_n", wr_n_o, !(m_ph == 2 && m_stb && m_wr));
      check(lo_bus_o == e_lo, "R3 lo_bus", lo_bus_o, e_lo);
      check(hi_bus_o == e_hi, "R4 hi_bus", hi_bus_o, e_hi);
      check(xram_en_o == (m_ph == 2 && m_x), "R12 xram_en", xram_en_o, m_ph == 2 && m_x);
      check(xram_we_o == (m_ph == 2 && m_x && m_wr), "R12 xram_we", xram_we_o, m_ph == 2 && m_x && m_wr);
      check(rdata_o == m_rd, "R11 rdata", rdata_o, m_rd);
      if (m_ph == 2 && m_x) begin
        check(xram_addr_o == m_addr, "R12 xram_addr", xram_addr_o, m_addr);
        if (m_wr) check(xram_wdata_o == m_wd, "R12 xram_wdata", xram_wdata_o, m_wd);
      end
      if (e_lo) begin
        logic [7:0] el;
        el = (m_ph == 1) ? m_addr[7:0] : (m_wr ? m_wd : 8'h00);
        check(lo_out_o == el, "R14 lo_out", lo_out_o, el);
      end
      if (e_hi) check(hi_out_o == m_addr[15:8], "R14 hi_out", hi_out_o, m_addr[15:8]);
    end
  end

  // ---------------- per-access monitors ----------------
  bit          seen_x, seen_rd, seen_wr, seen_lo, seen_hi;
  logic [15:0] last_xaddr;
  always @(posedge clk_i) begin
    if (xram_en_o) begin seen_x = 1; last_xaddr = xram_addr_o; end
    if (!rd_n_o) seen_rd = 1;
    if (!wr_n_o) seen_wr = 1;
    if (lo_bus_o) seen_lo = 1;
    if (hi_bus_o) seen_hi = 1;
  end

  task automatic set_cfg(input logic [7:0] pg, input logic [1:0] mp);
    @(negedge clk_i);
    cfg_we_i = 1; cfg_page_i = pg; cfg_map_i = mp;
    @(negedge clk_i);
    cfg_we_i = 0;
  endtask

  task automatic run_acc(input bit ptr, input bit wr, input logic [15:0] addr,
                         input logic [7:0] pg, input bit ex_x, input bit ex_stb,
                         input bit ex_lo, input bit ex_hi, input string tg);
    int n;
    @(negedge clk_i);
    req_ptr_i = ptr; req_write_i = wr; req_addr_i = addr; req_page_i = pg;
    req_wdata_i = addr[7:0] ^ 8'h5A;
    lo_in_i = 8'hA5; xram_rdata_i = 8'h3C;
    seen_x = 0; seen_rd = 0; seen_wr = 0; seen_lo = 0; seen_hi = 0;
    req_valid_i = 1;
    @(negedge clk_i);
    req_valid_i = 0;
    n = 1;
    while (!done_o && n < 20) begin @(negedge clk_i); n++; end
    check(n == 3, {tg, " R10 latency"}, n, 3);
    check(seen_x == ex_x, {tg, " target"}, seen_x, ex_x);
    check(seen_rd == (ex_stb && !wr), {tg, " rd strobe"}, seen_rd, ex_stb && !wr);
    check(seen_wr == (ex_stb && wr), {tg, " wr strobe"}, seen_wr, ex_stb && wr);
    check(seen_lo == ex_lo, {tg, " lo bus"}, seen_lo, ex_lo);
    check(seen_hi == ex_hi, {tg, " hi bus"}, seen_hi, ex_hi);
    if (!wr) check(rdata_o == (ex_x ? 8'h3C : 8'hA5), {tg, " R11 data"}, rdata_o, ex_x ? 8'h3C : 8'hA5);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check(busy_o == 0 && rd_n_o && wr_n_o && !lo_bus_o && !hi_bus_o, "R1 reset outputs",
          {busy_o, rd_n_o, wr_n_o, lo_bus_o, hi_bus_o}, 5'b01100);
    rst_ni = 1;
    @(negedge clk_i);
    check(busy_o == 0, "R1 idle after reset", busy_o, 0);

    // defaults: page F8, map 00, pin low
    run_acc(1, 1, 16'hF812, 8'h00, 1, 0, 1, 1, "R1 R5 ptr wr hit");
    run_acc(1, 0, 16'hF834, 8'h00, 1, 0, 0, 0, "R5 R9 ptr rd hit");
    run_acc(1, 0, 16'h1234, 8'h00, 0, 1, 1, 1, "R3 ptr rd miss");
    run_acc(1, 1, 16'h1234, 8'h00, 0, 1, 1, 1, "R3 ptr wr miss");
    run_acc(0, 1, 16'h0056, 8'h10, 0, 1, 1, 0, "R4 reg wr miss");
    run_acc(0, 1, 16'h0056, 8'hF8, 1, 0, 1, 0, "R4 R5 reg wr hit");
    check(last_xaddr == 16'hF856, "R12 reg-form xram addr", last_xaddr, 16'hF856);
    run_acc(1, 0, 16'h1020, 8'hF8, 0, 1, 1, 1, "R2 ptr uses addr byte");
    run_acc(0, 0, 16'hF820, 8'h10, 0, 1, 1, 0, "R2 reg uses page byte");

    // R13: second request while busy is dropped
    @(negedge clk_i);
    req_ptr_i = 1; req_write_i = 1; req_addr_i = 16'hF855; req_valid_i = 1;
    @(negedge clk_i);
    req_addr_i = 16'hF811;
    @(negedge clk_i);
    req_valid_i = 0;
    repeat (2) @(negedge clk_i);
    check(last_xaddr == 16'hF855, "R13 first request served", last_xaddr, 16'hF855);
    begin
      int dn = 0;
      repeat (6) begin @(negedge clk_i); if (done_o || busy_o) dn++; end
      check(dn == 0, "R13 busy request ignored", dn, 0);
    end

    set_cfg(8'h40, 2'b10);
    run_acc(1, 1, 16'h4001, 8'h00, 1, 1, 1, 1, "R6 ptr wr hit");
    run_acc(1, 0, 16'h4002, 8'h00, 1, 1, 0, 0, "R6 R9 ptr rd hit");
    run_acc(0, 0, 16'h0002, 8'h41, 0, 1, 1, 0, "R3 R6 reg rd miss");
    ext_acc_i = 1;
    run_acc(1, 1, 16'h4003, 8'h00, 1, 1, 1, 1, "R6 pin high");
    ext_acc_i = 0;

    set_cfg(8'h40, 2'b01);
    run_acc(1, 1, 16'h4003, 8'h00, 0, 1, 1, 1, "R7 map01 hit");
    set_cfg(8'h40, 2'b11);
    run_acc(1, 0, 16'h4004, 8'h00, 0, 1, 1, 1, "R7 map11 hit rd");
    run_acc(0, 1, 16'h0004, 8'h40, 0, 1, 1, 0, "R7 R4 reg hit");

    set_cfg(8'h40, 2'b00);
    ext_acc_i = 1;
    run_acc(1, 1, 16'h4005, 8'h00, 1, 0, 0, 0, "R8 ptr wr hit");
    run_acc(0, 0, 16'h0009, 8'h40, 1, 0, 0, 0, "R8 R9 reg rd hit");
    check(last_xaddr == 16'h4009, "R12 reg-form xram addr", last_xaddr, 16'h4009);
    run_acc(1, 0, 16'h5000, 8'h00, 0, 1, 1, 1, "R3 pin high miss");

    repeat (3) @(negedge clk_i);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule